// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block steers a five-stage, single-issue, in-order pipeline: fetch (IF), decode and register read (ID), execute (EX), memory access (MA) and write-back (WB). It keeps a small control-only copy of the instruction in each stage from ID to WB. That copy holds a valid bit, four class flags (load, store, branch, ALU) and the two source and one destination register indices. From these copies it works out, every cycle, which stages must hold, where a bubble goes, and where each of the two EX operands must come from. The datapath, the memories and the register file lie outside the block.

Two hazards are handled. The first is a consumer in EX that reads the destination of a load still in MA. The load data only exists at the end of MA, so IF, ID and EX hold for one cycle and MA receives an empty slot. On the next cycle the load has reached WB and its data is forwarded from there. The second is a branch. Once a branch has been fetched, nothing new is fetched while it sits in ID and in EX. In the cycle after EX resolves it, the block tells fetch to restart and whether to use the taken target or the fall-through address. There is no prediction.

Forwarding draws on two places: the ALU result held in the EX/MA register, and the ALU or load result held in the MA/WB register. When both hold the register that is needed, the younger one wins. Register 0 is hard-wired to zero and never produces a match.

Top module: `hazard_ctrl`

## Requirements
- R1: While reset is low at a rising edge, every stage copy is emptied. In the following cycle all stall and bubble outputs are 0, both forwarding selects are 0 and `redirect_vld` is 0.
- R2: A load-use hazard exists when a valid load with a nonzero destination sits in MA and a valid instruction in EX reads that register through either source. During that cycle `stall_if`, `stall_id`, `stall_ex` and `bubble_ma` are 1, and they return to 0 the cycle after.
- R3: In the cycle after a load-use stall, the held consumer sees the load in WB. Its matching operand select is 2 (from MA/WB) and no further stall is raised.
- R4: A source index of 0 never matches a destination, so it never causes a stall and never selects a forwarded value, even when a load or ALU op writing register 0 is in flight.
- R5: Each operand select is encoded as 0 for the register file, 1 for the ALU result in the EX/MA register and 2 for the result in the MA/WB register. Operand A (rs1) and operand B (rs2) are chosen independently, and code 3 never appears.
- R6: When both the EX/MA and the MA/WB registers hold a valid write to the needed register, and the EX/MA entry is an ALU op, the select is 1.
- R7: The data register of a store (its rs2) takes part in load-use detection like any source. The destination field of a store, like that of a branch, is never treated as written, so it causes no forwarding and no stall.
- R8: While a valid branch is in ID or in EX and no load-use stall is active, `stall_if` and `bubble_id` are 1. As a result, nothing is fetched in the two cycles after the branch is fetched.
- R9: In the cycle after a branch leaves EX, `redirect_vld` is 1 for exactly one cycle and `redirect_taken` equals the `ex_br_taken` value driven as the branch left EX. In that same cycle `stall_if` is 0.
- R10: A branch that is held in EX by a load-use stall does not resolve in the stall cycle. The `ex_br_taken` value from that cycle is ignored, and the redirect comes one cycle later with the outcome driven on the cycle the branch leaves EX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| if_valid | input | 1 | IF holds an instruction this cycle |
| if_is_load | input | 1 | IF instruction is a load |
| if_is_store | input | 1 | IF instruction is a store |
| if_is_branch | input | 1 | IF instruction is a conditional branch |
| if_is_alu | input | 1 | IF instruction is an ALU op writing a register |
| if_rs1 | input | 5 | First source index (0 = none) |
| if_rs2 | input | 5 | Second source index, store data for stores (0 = none) |
| if_rd | input | 5 | Destination index |
| ex_br_taken | input | 1 | Outcome of the branch now in EX, 1 = taken |
| stall_if | output | 1 | Hold the fetch address, fetch nothing new |
| stall_id | output | 1 | Hold the ID stage register |
| stall_ex | output | 1 | Hold the EX stage register |
| bubble_id | output | 1 | ID receives an empty slot next cycle (branch pending) |
| bubble_ma | output | 1 | MA receives an empty slot next cycle (load-use) |
| fwd_a_sel | output | 2 | Source select for EX operand A |
| fwd_b_sel | output | 2 | Source select for EX operand B |
| redirect_vld | output | 1 | Fetch restarts after a resolved branch |
| redirect_taken | output | 1 | Restart at the taken target (1) or the fall-through address (0) |

## Verification
The hardest case to reach from the ports is a branch that reads a register loaded by the instruction just ahead of it. In that case the branch hold and the load-use stall are active together, and the redirect is pushed back by a cycle. The stimulus table reaches this with a load followed directly by a branch on that load's destination. It drives a taken flag of 0 in the stall cycle and 1 on the real resolve cycle, so that sampling the outcome too early shows up at `redirect_taken`. Other rows set up the priority case, with an ALU op and a load to the same register one stage apart, and a store whose data register depends on a preceding load.

// File: rtl/hz_pkg.sv
// Package: shared types and helpers for the hazard controller.
// Assumes one instruction per stage and at most one class flag set per instruction.
package hz_pkg;

    parameter int NREG   = 32;
    localparam int REG_AW = $clog2(NREG);
    localparam int NSTAGE = 4;   // ID, EX, MA, WB copies kept by the controller
    localparam int NSRC   = 2;   // source operands per instruction
    localparam int S_ID   = 0;
    localparam int S_EX   = 1;
    localparam int S_MA   = 2;
    localparam int S_WB   = 3;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef struct packed {
        logic     valid;
        logic     is_load;
        logic     is_store;
        logic     is_branch;
        logic     is_alu;
        reg_idx_t rs1;
        reg_idx_t rs2;
        reg_idx_t rd;
    } stage_ctl_t;

    localparam stage_ctl_t CTL_NONE = '0;

    typedef enum logic [1:0] {
        FWD_RF   = 2'd0,
        FWD_EXMA = 2'd1,
        FWD_MAWB = 2'd2
    } fwd_sel_e;

    // True when the stage will write a nonzero register.
    function automatic logic writes_reg(stage_ctl_t s);
        return s.valid && (s.is_load || s.is_alu) && (s.rd != '0);
    endfunction

    // True when the stage reads register r through either source; register 0 never matches.
    function automatic logic reads_reg(stage_ctl_t s, reg_idx_t r);
        return s.valid && (r != '0) && ((s.rs1 == r) || (s.rs2 == r));
    endfunction

endpackage

// File: rtl/hz_stage_regs.sv
// Module: control copies of the instruction in ID, EX, MA and WB.
// On a load-use stall ID and EX hold and MA takes an empty slot. While a
// branch is pending, ID takes an empty slot. Reset is synchronous, active low.
module hz_stage_regs
    import hz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stage_ctl_t if_ctl,
    input  logic       lu_stall,
    input  logic       branch_wait,
    output stage_ctl_t st [NSTAGE]
);

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        if (k == S_ID) begin : g_id
            // ID: hold on load-use, empty slot behind a pending branch, else take IF.
            always_ff @(posedge clk) begin
                if (!rst_n)                          st[k] <= CTL_NONE;
                else if (lu_stall)                   st[k] <= st[k];
                else if (branch_wait || !if_ctl.valid) st[k] <= CTL_NONE;
                else                                 st[k] <= if_ctl;
            end
        end else if (k == S_EX) begin : g_ex
            // EX: hold the consumer during a load-use stall, else advance from ID.
            always_ff @(posedge clk) begin
                if (!rst_n)        st[k] <= CTL_NONE;
                else if (lu_stall) st[k] <= st[k];
                else               st[k] <= st[k-1];
            end
        end else if (k == S_MA) begin : g_ma
            // MA: take an empty slot while EX is held, else advance from EX.
            always_ff @(posedge clk) begin
                if (!rst_n)        st[k] <= CTL_NONE;
                else if (lu_stall) st[k] <= CTL_NONE;
                else               st[k] <= st[k-1];
            end
        end else begin : g_tail
            // Later stages never stall: plain shift.
            always_ff @(posedge clk) begin
                if (!rst_n) st[k] <= CTL_NONE;
                else        st[k] <= st[k-1];
            end
        end
    end

    AST_MA_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        lu_stall |=> !st[S_MA].valid);                                    // R2
    AST_EX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        lu_stall |=> $stable(st[S_EX]));                                  // R2
    AST_NOTHING_BEHIND_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st[S_ID].valid && st[S_ID].is_branch && !lu_stall) |=> !st[S_ID].valid); // R8

endmodule

// File: rtl/hz_hazard_detect.sv
// Module: load-use and branch-hold detection, and the stage stall/bubble enables.
// Assumes the stage copies come straight from hz_stage_regs.
module hz_hazard_detect
    import hz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stage_ctl_t id_ctl,
    input  stage_ctl_t ex_ctl,
    input  stage_ctl_t ma_ctl,
    output logic       lu_stall,
    output logic       branch_wait,
    output logic       stall_if,
    output logic       stall_id,
    output logic       stall_ex,
    output logic       bubble_id,
    output logic       bubble_ma
);

    logic ma_is_load_wr;
    logic br_in_id;
    logic br_in_ex;

    // Load-use: a load in MA whose destination the EX instruction reads (store data included).
    always_comb begin
        ma_is_load_wr = ma_ctl.is_load && writes_reg(ma_ctl);
        lu_stall      = ma_is_load_wr && reads_reg(ex_ctl, ma_ctl.rd);
    end

    // Branch hold: a valid branch in ID or EX blocks further fetching.
    always_comb begin
        br_in_id    = id_ctl.valid && id_ctl.is_branch;
        br_in_ex    = ex_ctl.valid && ex_ctl.is_branch;
        branch_wait = br_in_id || br_in_ex;
    end

    // Per-stage enables derived from the two hazards.
    always_comb begin
        stall_if  = lu_stall || branch_wait;
        stall_id  = lu_stall;
        stall_ex  = lu_stall;
        bubble_ma = lu_stall;
        bubble_id = branch_wait && !lu_stall;
    end

    AST_LU_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lu_stall |=> !lu_stall);                                          // R2
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ex_ctl.valid |-> $onehot0({ex_ctl.is_load, ex_ctl.is_store,
                                   ex_ctl.is_branch, ex_ctl.is_alu}));    // R7

endmodule

// File: rtl/hz_fwd_unit.sv
// Module: forwarding selects for the EX operands.
// Picks the youngest valid producer. A load still in MA is not usable
// (a load-use stall covers that cycle). Source index 0 always reads the register file.
module hz_fwd_unit
    import hz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stage_ctl_t ex_ctl,
    input  stage_ctl_t ma_ctl,
    input  stage_ctl_t wb_ctl,
    output fwd_sel_e   sel [NSRC]
);

    for (genvar g = 0; g < NSRC; g++) begin : g_opnd
        reg_idx_t src;
        assign src = (g == 0) ? ex_ctl.rs1 : ex_ctl.rs2;

        // Choose the youngest legal producer for this operand.
        always_comb begin
            sel[g] = FWD_RF;
            if (ex_ctl.valid && src != '0) begin
                if (writes_reg(ma_ctl) && ma_ctl.rd == src)
                    sel[g] = ma_ctl.is_alu ? FWD_EXMA : FWD_RF;
                else if (writes_reg(wb_ctl) && wb_ctl.rd == src)
                    sel[g] = FWD_MAWB;
            end
        end

        AST_FWD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            sel[g] != fwd_sel_e'(2'd3));                                  // R5
        AST_FWD_NO_X0: assert property (@(posedge clk) disable iff (!rst_n)
            (src == '0) |-> (sel[g] == FWD_RF));                          // R4
    end

endmodule

// File: rtl/hz_redirect.sv
// Module: registers the branch outcome when the branch leaves EX.
// The fetch restart is flagged for the one following cycle. A branch held in
// EX by a load-use stall is not resolved until it moves on.
module hz_redirect
    import hz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stage_ctl_t ex_ctl,
    input  logic       lu_stall,
    input  logic       ex_br_taken,
    output logic       redirect_vld,
    output logic       redirect_taken
);

    logic resolve_now;

    // A branch resolves on the cycle it advances out of EX.
    always_comb begin
        resolve_now = ex_ctl.valid && ex_ctl.is_branch && !lu_stall;
    end

    // Capture the outcome for the fetch restart in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_vld   <= 1'b0;
            redirect_taken <= 1'b0;
        end else begin
            redirect_vld   <= resolve_now;
            redirect_taken <= resolve_now ? ex_br_taken : 1'b0;
        end
    end

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |=> !redirect_vld);                                  // R9

endmodule

// File: rtl/hazard_ctrl.sv
// Module: top of the pipeline hazard stall controller.
// Collects the IF-side instruction class and register indices, keeps per-stage
// control copies, and drives stalls, bubbles, forwarding selects and the fetch
// restart after a branch. All outputs except the restart pair are
// combinational from the stage copies.
module hazard_ctrl
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_valid,
    input  logic              if_is_load,
    input  logic              if_is_store,
    input  logic              if_is_branch,
    input  logic              if_is_alu,
    input  logic [REG_AW-1:0] if_rs1,
    input  logic [REG_AW-1:0] if_rs2,
    input  logic [REG_AW-1:0] if_rd,
    input  logic              ex_br_taken,
    output logic              stall_if,
    output logic              stall_id,
    output logic              stall_ex,
    output logic              bubble_id,
    output logic              bubble_ma,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              redirect_vld,
    output logic              redirect_taken
);

    stage_ctl_t if_ctl;
    stage_ctl_t st [NSTAGE];
    fwd_sel_e   sel [NSRC];
    logic       lu_stall;
    logic       branch_wait;

    // Bundle the IF-side fields into one stage record.
    always_comb begin
        if_ctl = '{valid: if_valid, is_load: if_is_load, is_store: if_is_store,
                   is_branch: if_is_branch, is_alu: if_is_alu,
                   rs1: if_rs1, rs2: if_rs2, rd: if_rd};
    end

    hz_stage_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .if_ctl      (if_ctl),
        .lu_stall    (lu_stall),
        .branch_wait (branch_wait),
        .st          (st)
    );

    hz_hazard_detect u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_ctl      (st[S_ID]),
        .ex_ctl      (st[S_EX]),
        .ma_ctl      (st[S_MA]),
        .lu_stall    (lu_stall),
        .branch_wait (branch_wait),
        .stall_if    (stall_if),
        .stall_id    (stall_id),
        .stall_ex    (stall_ex),
        .bubble_id   (bubble_id),
        .bubble_ma   (bubble_ma)
    );

    hz_fwd_unit u_fwd (
        .clk    (clk),
        .rst_n  (rst_n),
        .ex_ctl (st[S_EX]),
        .ma_ctl (st[S_MA]),
        .wb_ctl (st[S_WB]),
        .sel    (sel)
    );

    hz_redirect u_redir (
        .clk            (clk),
        .rst_n          (rst_n),
        .ex_ctl         (st[S_EX]),
        .lu_stall       (lu_stall),
        .ex_br_taken    (ex_br_taken),
        .redirect_vld   (redirect_vld),
        .redirect_taken (redirect_taken)
    );

    // Map the operand selects onto the output ports.
    always_comb begin
        fwd_a_sel = sel[0];
        fwd_b_sel = sel[1];
    end

    AST_RESUME_ON_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> !stall_if);                                      // R9
    AST_BRANCH_IN_EX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st[S_EX].valid && st[S_EX].is_branch) |-> stall_if);             // R8
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!redirect_vld && !stall_if && fwd_a_sel == 2'd0));    // R1

endmodule

// File: tb/sim_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_ctrl;

    localparam real HALF = 2.5;   // 200 MHz
    localparam int  NV   = 26;

    // Instruction class codes, ordered {load, store, branch, alu}.
    localparam logic [3:0] LD = 4'b1000, ST = 4'b0100, BR = 4'b0010, AL = 4'b0001;

    function automatic logic [19:0] ins(logic [3:0] cls, int a, int b, int d);
        logic [4:0] a5, b5, d5;
        a5 = a[4:0]; b5 = b[4:0]; d5 = d[4:0];
        return {1'b1, cls, a5, b5, d5};
    endfunction

    localparam logic [19:0] NOP = 20'd0;

    // Row: {IF instruction, ex_br_taken}.
    localparam logic [20:0] VIN [NV] = '{
        {ins(AL,0,0,3),1'b0},  {ins(AL,0,0,4),1'b0},  {ins(LD,4,0,6),1'b0},
        {ins(AL,5,6,5),1'b0},  {ins(AL,4,0,4),1'b0},  {ins(AL,4,0,4),1'b0},
        {ins(BR,4,3,0),1'b0},  {NOP,1'b0},            {NOP,1'b0},
        {ins(ST,0,5,7),1'b0},  {ins(AL,7,7,8),1'b0},  {ins(LD,0,0,9),1'b0},
        {ins(AL,0,0,9),1'b0},  {ins(ST,9,9,0),1'b0},  {ins(LD,0,0,10),1'b0},
        {ins(ST,0,10,0),1'b0}, {ins(LD,0,0,0),1'b0},  {ins(LD,0,0,0),1'b0},
        {ins(AL,0,0,11),1'b0}, {ins(LD,0,0,12),1'b0}, {ins(BR,12,0,0),1'b0},
        {NOP,1'b0},            {NOP,1'b0},            {NOP,1'b1},
        {NOP,1'b0},            {NOP,1'b0}
    };

    // Expected {stall_if,stall_id,stall_ex,bubble_id,bubble_ma,fwd_a,fwd_b,redirect_vld,redirect_taken}.
    localparam logic [10:0] VEXP [NV] = '{
        11'b00000_00_00_00, 11'b00000_00_00_00, 11'b00000_00_00_00,
        11'b00000_00_00_00, 11'b00000_01_00_00, 11'b11101_00_00_00,
        11'b00000_00_10_00, 11'b10010_00_00_00, 11'b10010_01_00_00,
        11'b00000_00_00_10, 11'b00000_00_00_00, 11'b00000_00_00_00,
        11'b00000_00_00_00, 11'b00000_00_00_00, 11'b00000_00_00_00,
        11'b00000_01_01_00, 11'b00000_00_00_00, 11'b11101_00_00_00,
        11'b00000_00_10_00, 11'b00000_00_00_00, 11'b00000_00_00_00,
        11'b10010_00_00_00, 11'b11101_00_00_00, 11'b10010_10_00_00,
        11'b00000_00_00_11, 11'b00000_00_00_00
    };

    function automatic string req_of(int i);
        case (i)
            0:                       return "R1";
            4, 13, 14:               return "R5";
            5:                       return "R2";
            6, 18:                   return "R3";
            7, 8, 21:                return "R8";
            9, 10:                   return "R9";
            11, 12, 16, 17:          return "R7";
            15:                      return "R6";
            19, 20:                  return "R4";
            22, 23, 24, 25:          return "R10";
            default:                 return "R5";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       if_valid = 1'b0, if_is_load = 1'b0, if_is_store = 1'b0;
    logic       if_is_branch = 1'b0, if_is_alu = 1'b0, ex_br_taken = 1'b0;
    logic [4:0] if_rs1 = '0, if_rs2 = '0, if_rd = '0;
    logic       stall_if, stall_id, stall_ex, bubble_id, bubble_ma;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       redirect_vld, redirect_taken;
    int         n_chk = 0;
    int         n_err = 0;

    always #HALF clk = ~clk;

    hazard_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_is_load(if_is_load),
        .if_is_store(if_is_store), .if_is_branch(if_is_branch), .if_is_alu(if_is_alu),
        .if_rs1(if_rs1), .if_rs2(if_rs2), .if_rd(if_rd), .ex_br_taken(ex_br_taken),
        .stall_if(stall_if), .stall_id(stall_id), .stall_ex(stall_ex),
        .bubble_id(bubble_id), .bubble_ma(bubble_ma), .fwd_a_sel(fwd_a_sel),
        .fwd_b_sel(fwd_b_sel), .redirect_vld(redirect_vld), .redirect_taken(redirect_taken)
    );

    function automatic logic [10:0] outs();
        return {stall_if, stall_id, stall_ex, bubble_id, bubble_ma,
                fwd_a_sel, fwd_b_sel, redirect_vld, redirect_taken};
    endfunction

    task automatic drive(logic [19:0] w, logic tk);
        {if_valid, if_is_load, if_is_store, if_is_branch, if_is_alu,
         if_rs1, if_rs2, if_rd} = w;
        ex_br_taken = tk;
    endtask

    task automatic chk(string tag, logic [10:0] exp);
        logic [10:0] got;
        got = outs();
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    initial begin : watchdog
        #(2.0 * HALF * 200000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : stimulus
        drive(NOP, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Table: outputs are checked within the cycle in which each row's IF input is presented.
        for (int i = 0; i < NV; i++) begin
            drive(VIN[i][20:1], VIN[i][0]);
            #1;
            chk(req_of(i), VEXP[i]);
            @(negedge clk);
        end
        // Directed: ALU producer then consumer, forward from EX/MA (R5).
        drive(ins(AL,0,0,3), 1'b0);  @(negedge clk);
        drive(ins(AL,3,0,4), 1'b0);  @(negedge clk);
        drive(NOP, 1'b0);            @(negedge clk);
        #1; chk("R5 directed", 11'b00000_01_00_00);
        // Directed: reset while producers are in flight clears everything (R1).
        drive(ins(BR,0,0,0), 1'b0);  @(negedge clk);
        rst_n = 1'b0;                @(negedge clk);
        #1; chk("R1 mid-run reset", 11'b00000_00_00_00);
        rst_n = 1'b1;
        drive(NOP, 1'b1);            @(negedge clk);
        #1; chk("R1 after release", 11'b00000_00_00_00);
        @(negedge clk);
        #1; chk("R1 no stale redirect", 11'b00000_00_00_00);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule